// File: doc/BRIEF.md
# Debug Watchpoint Command Engine

This block sits behind the byte channel of an on-chip debug port and handles the two commands that set and inspect the hardware watchpoint. Bytes arrive on a valid/ready input stream. The first byte of each command is an opcode. A write command stores the next three bytes into the watchpoint control, address and data registers. A read command streams those three registers back on a valid/ready output stream. The comparison of the watchpoint against CPU bus traffic is done elsewhere. That logic reads the register contents, which this block only stores.

The block has two plain status inputs. One says whether the chip is in debug mode. The other says whether read protection is active. When either of them blocks access, a write leaves the control register at zero, so the watchpoint cannot be armed. The address and data registers are still written.

Back-pressure rules are as follows. An input byte is taken on any rising edge where `in_valid` and `in_ready` are both high. `in_ready` drops while a read-back is in progress, so no new opcode is taken until the last returned byte has been accepted. On the output side, `out_valid` stays high and `out_data` stays unchanged until `out_ready` is seen high on a clock edge. The next byte follows in the cycle after that edge.

Top module: `wpt_cmd_engine`

## Requirements
- R1: After reset all three watchpoint registers hold 0x00, `in_ready` is 1 and `out_valid` is 0.
- R2: An accepted opcode byte 0x20 is followed by exactly three payload bytes, stored in the order control, address, data. Each payload byte is written on the clock edge that accepts it, so a read issued immediately afterwards returns it.
- R3: If `dbg_active` is 0 or `protect_on` is 1 on the edge that accepts the control payload byte, the control register is set to 0x00. The address and data bytes of the same command are stored unchanged.
- R4: An accepted opcode byte 0x21 produces three output bytes in the order control, address, data.
- R5: While `out_valid` is 1 and `out_ready` is 0, the next cycle still has `out_valid` at 1 and `out_data` unchanged.
- R6: From the cycle after a read opcode is accepted until the edge that accepts the third returned byte, `in_ready` is 0. In every other cycle it is 1.
- R7: An opcode byte other than 0x20 or 0x21 changes no register and starts no output. The byte after it is decoded as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input command or payload byte |
| in_ready | output | 1 | Engine can take an input byte |
| out_valid | output | 1 | Read-back byte present |
| out_data | output | 8 | Read-back byte |
| out_ready | input | 1 | Consumer takes the read-back byte |
| dbg_active | input | 1 | Chip is in debug mode |
| protect_on | input | 1 | Read protection is active |

## Verification
Two functions can fall in the same cycle: the acceptance of the last read-back byte and the arrival of the next command opcode. The bench provokes this by presenting a second read opcode while the first read-back is still stalled by an irregular `out_ready` pattern. It judges the result by confirming that the scoreboard already holds no pending bytes when that opcode is taken. The same timing question arises between a write and a read: a read issued straight after the last payload byte must return the new data. The bench also exercises the protection gating by changing `dbg_active` and `protect_on` between write commands.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned NUM_WREG = 3;

  typedef enum logic [0:0] {
    PS_OPCODE  = 1'b0,
    PS_PAYLOAD = 1'b1
  } pstate_t;
endpackage

// File: rtl/wpt_parser.sv
module wpt_parser
  import wpt_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter int unsigned N = 3,
  parameter logic [W-1:0] OPC_WR = 8'h20,
  parameter logic [W-1:0] OPC_RD = 8'h21,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [W-1:0]     in_data,
  input  logic             rd_busy,
  output logic             in_ready,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [W-1:0]     wr_data,
  output logic             rd_start
);
  pstate_t          state;
  logic [IDX_W-1:0] pay_idx;
  logic             fire;

  assign in_ready = !rd_busy;
  assign fire     = in_valid && in_ready;
  assign wr_data  = in_data;
  assign wr_idx   = pay_idx;

  always_comb begin
    wr_en    = 1'b0;
    rd_start = 1'b0;
    if (fire) begin
      if (state == PS_PAYLOAD) wr_en = 1'b1;
      else if (in_data == OPC_RD) rd_start = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= PS_OPCODE;
      pay_idx <= '0;
    end else if (fire) begin
      case (state)
        PS_OPCODE: begin
          if (in_data == OPC_WR) begin
            state   <= PS_PAYLOAD;
            pay_idx <= '0;
          end
        end
        PS_PAYLOAD: begin
          if (pay_idx == IDX_W'(N - 1)) begin
            state   <= PS_OPCODE;
            pay_idx <= '0;
          end else begin
            pay_idx <= pay_idx + 1'b1;
          end
        end
        default: state <= PS_OPCODE;
      endcase
    end
  end

  // R6: once a read opcode is taken, the input stalls on the next cycle
  assert_rd_stalls_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> !in_ready);

  // R6: a payload is never pending while read-back is running
  assert_no_payload_in_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_PAYLOAD) |-> !rd_busy);
endmodule

// File: rtl/wpt_regfile.sv
module wpt_regfile #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 3,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic             ctl_allow,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     rd_data
);
  logic [N-1:0][W-1:0] regs;

  for (genvar g = 0; g < N; g++) begin : g_reg
    if (g == 0) begin : g_ctl
      always_ff @(posedge clk) begin
        if (!rst_n) regs[g] <= '0;
        else if (wr_en && wr_idx == IDX_W'(g)) regs[g] <= ctl_allow ? wr_data : '0;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n) regs[g] <= '0;
        else if (wr_en && wr_idx == IDX_W'(g)) regs[g] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = regs[i];
    end
  end

  // R3: a blocked control write leaves zero
  assert_ctl_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == '0 && !ctl_allow) |=> (regs[0] == '0));

  // R7: without a payload write every register keeps its value
  assert_regs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs));
endmodule

// File: rtl/wpt_readout.sv
module wpt_readout #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 3,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_start,
  input  logic             out_ready,
  input  logic [W-1:0]     rd_data,
  output logic             busy,
  output logic [IDX_W-1:0] rd_idx,
  output logic             out_valid,
  output logic [W-1:0]     out_data
);
  assign out_valid = busy;
  assign out_data  = rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      rd_idx <= '0;
    end else if (rd_start) begin
      busy   <= 1'b1;
      rd_idx <= '0;
    end else if (busy && out_ready) begin
      if (rd_idx == IDX_W'(N - 1)) begin
        busy   <= 1'b0;
        rd_idx <= '0;
      end else begin
        rd_idx <= rd_idx + 1'b1;
      end
    end
  end

  // R5: a stalled output byte is held
  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R6: a read never starts on top of a running one
  assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |-> !busy);
endmodule

// File: rtl/wpt_cmd_engine.sv
module wpt_cmd_engine
  import wpt_pkg::*;
#(
  parameter int unsigned W = BYTE_W,
  parameter int unsigned N = NUM_WREG,
  parameter logic [W-1:0] OPC_WR = 8'h20,
  parameter logic [W-1:0] OPC_RD = 8'h21
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready,
  input  logic         dbg_active,
  input  logic         protect_on
);
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

  logic             rd_busy;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [W-1:0]     wr_data;
  logic             rd_start;
  logic [IDX_W-1:0] rd_idx;
  logic [W-1:0]     rd_data;
  logic             ctl_allow;

  assign ctl_allow = dbg_active && !protect_on;

  wpt_parser #(.W(W), .N(N), .OPC_WR(OPC_WR), .OPC_RD(OPC_RD)) u_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .rd_busy(rd_busy), .in_ready(in_ready), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_start(rd_start)
  );

  wpt_regfile #(.W(W), .N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .ctl_allow(ctl_allow), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  wpt_readout #(.W(W), .N(N)) u_readout (
    .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .out_ready(out_ready),
    .rd_data(rd_data), .busy(rd_busy), .rd_idx(rd_idx),
    .out_valid(out_valid), .out_data(out_data)
  );

  // R1: output idle in the cycle after reset
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && in_ready));
endmodule

// File: tb/wpt_cmd_engine_bench.sv
`timescale 1ns/1ps
module wpt_cmd_engine_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ready = 1'b0;
  logic       dbg_active = 1'b0;
  logic       protect_on = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit rdy_free = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] mdl [3];

  always #4 clk = ~clk;

  wpt_cmd_engine u_wpt_cmd_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .dbg_active(dbg_active), .protect_on(protect_on)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // out_ready driver: irregular pattern, changes 1 ns after the edge
  logic [7:0] lfsr = 8'h5b;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = rdy_free ? 1'b1 : lfsr[0];
  end

  // monitor: pops expected bytes as they are accepted, checks hold
  logic       hold_pend = 1'b0;
  logic [7:0] hold_val;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        check(out_valid && out_data == hold_val, "R5 hold", out_data, hold_val);
      end
      hold_pend = 1'b0;
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected output", out_data, 8'h00);
        end else if (out_ready) begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_data == e, t, out_data, e);
        end else begin
          hold_pend = 1'b1;
          hold_val  = out_data;
        end
      end
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] c, input logic [7:0] a, input logic [7:0] d);
    send(8'h20);
    send(c);
    mdl[0] = (dbg_active && !protect_on) ? c : 8'h00;
    send(a);
    mdl[1] = a;
    send(d);
    mdl[2] = d;
  endtask

  task automatic do_read(input string req);
    send(8'h21);
    for (int i = 0; i < 3; i++) begin
      exp_q.push_back(mdl[i]);
      tag_q.push_back(req);
    end
  endtask

  task automatic drain;
    int n = 0;
    while (exp_q.size() != 0 && n < 200) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R4 drain", 8'(exp_q.size()), 8'h00);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(in_ready == 1'b1, "R1 in_ready", {7'b0, in_ready}, 8'h01);
    check(out_valid == 1'b0, "R1 out_valid", {7'b0, out_valid}, 8'h00);
    do_read("R1 reset contents");
    drain();

    // R2 / R4: enabled write, then read back in order
    dbg_active = 1'b1;
    do_write(8'hA5, 8'h3C, 8'h7E);
    do_read("R2 R4 write order");
    drain();

    // R3: protection blocks control byte
    protect_on = 1'b1;
    do_write(8'hFF, 8'h11, 8'h22);
    do_read("R3 protect gating");
    drain();

    // R3: outside debug mode
    protect_on = 1'b0;
    dbg_active = 1'b0;
    do_write(8'h81, 8'h44, 8'h55);
    do_read("R3 debug gating");
    drain();

    // R7: unknown opcodes ignored, next byte decoded as opcode
    dbg_active = 1'b1;
    do_write(8'h5A, 8'h66, 8'h77);
    send(8'hA5);
    send(8'h33);
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R7 no output", {7'b0, out_valid}, 8'h00);
    check(in_ready == 1'b1, "R7 in_ready", {7'b0, in_ready}, 8'h01);
    do_read("R7 unchanged");
    drain();

    // R6: second read opcode waits for first read-back to finish
    do_write(8'h12, 8'h34, 8'h56);
    send(8'h21);
    for (int i = 0; i < 3; i++) begin
      exp_q.push_back(mdl[i]);
      tag_q.push_back("R6 first read");
    end
    @(negedge clk);
    check(in_ready == 1'b0 || exp_q.size() == 0, "R6 stalled", {7'b0, in_ready}, 8'h00);
    send(8'h21);
    check(exp_q.size() == 0, "R6 opcode after readback", 8'(exp_q.size()), 8'h00);
    for (int i = 0; i < 3; i++) begin
      exp_q.push_back(mdl[i]);
      tag_q.push_back("R6 second read");
    end
    drain();
    check(in_ready == 1'b1, "R6 in_ready idle", {7'b0, in_ready}, 8'h01);

    // R2: read straight after write sees new data, consumer always ready
    rdy_free = 1'b1;
    do_write(8'hC3, 8'h9D, 8'hE1);
    do_read("R2 immediate read");
    drain();
    rdy_free = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule